// File: doc/BRIEF.md
# Audio Clock Configuration Controller

This block is the control logic of a multi-output audio clock generator. It runs on the master clock and turns a small set of pins into a stable configuration. That configuration covers which clock outputs are enabled, whether the sampling rate is standard or double, and which sampling group (48 kHz, 44.1 kHz or 32 kHz) is selected. It then derives the frequency multiplier that each of the four synthesised outputs must use. A downstream PLL sequencer consumes these outputs and re-settles whenever the one-cycle change pulse fires.

A mode pin picks the meaning of three shared pins. In serial mode they act as a latch strobe, a shift clock and a data line. A 16-bit word is shifted in MSB first, and it is applied only if its address tag and its fields are legal. In parallel mode the same three pins directly select the rate and the group, and every output is enabled. A reset stretcher holds the block in its default state while the reset pin is low or a power-on pulse is present, and for a parameterised number of clocks after either one ends.

Top module: `clkcfg_ctrl`

## Requirements
- R1: While the internal reset is active (`rst_busy_o` high), the outputs carry the defaults: all six enables 1, `rate_dbl_o` 0 and `group_o` 00. `cfg_changed_o` stays low during that time.
- R2: `rst_busy_o` goes low exactly `STRETCH_CYCLES` clock edges after `rst_ni` rises. A one-cycle `por_i` pulse restarts the same count and restores the serial register to defaults.
- R3: In serial mode (mode pin 0), data bits are captured on rising edges of the shift clock, MSB first. A rising edge of the latch strobe applies the word with this layout:
  - bits 15..10 are the address tag 011100;
  - bit 3 must be 0;
  - bits 9..4 go to `out_en_o[5:0]` (bit 9 to `out_en_o[5]`);
  - bit 2 goes to `rate_dbl_o` (1 = double);
  - bits 1..0 go to `group_o` (00 = 48 kHz, 01 = 44.1 kHz, 10 = 32 kHz, 11 reserved).
- R4: A latched word whose address tag differs from 011100 leaves the configuration unchanged.
- R5: A latch preceded by fewer than 16 shift-clock edges since the previous latch is ignored. When more than 16 bits were shifted, the last 16 are used.
- R6: A latched word with group code 11 or with bit 3 set is ignored.
- R7: In parallel mode (mode pin 1):
  - `ml_sr_i` gives the rate;
  - `{mc_fs1_i, md_fs0_i}` give the group, using the same encoding as R3;
  - the reserved code 11 is treated as 00;
  - all six enables read 1.
- R8: The serial register keeps its value while parallel mode is selected and is shown again on the return to serial mode.
- R9: `mult_o` holds one 2-bit code per output (0 = 256 fS, 1 = 384 fS, 2 = 768 fS):
  - `mult_o[1:0]` (channel 0) is always 768;
  - `mult_o[3:2]` (channel 1) is 256;
  - `mult_o[5:4]` (channel 2) is 384;
  - `mult_o[7:6]` (channel 3) is 768 at standard rate and 384 at double rate.
- R10: `cfg_changed_o` pulses for exactly one cycle each time the output configuration changes outside reset. It does not pulse for a write that equals the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset pin |
| por_i | input | 1 | Power-on pulse, active high, synchronous |
| mode_i | input | 1 | 0 selects serial, 1 selects parallel |
| ml_sr_i | input | 1 | Serial latch strobe / parallel rate select |
| mc_fs1_i | input | 1 | Serial shift clock / parallel group bit 1 |
| md_fs0_i | input | 1 | Serial data / parallel group bit 0 |
| out_en_o | output | 6 | Per-output enables |
| rate_dbl_o | output | 1 | 1 = double sampling rate |
| group_o | output | 2 | Sampling group code |
| mult_o | output | 8 | Four 2-bit multiplier codes, channel 0 in the low bits |
| cfg_changed_o | output | 1 | One-cycle pulse on configuration change |
| rst_busy_o | output | 1 | Internal reset active |

## Verification
The bench builds the block with `STRETCH_CYCLES` set to 16 and two synchroniser stages. With that setting the release of both reset sources can be counted edge by edge against the exact figure, while the sweeps stay short. This brings every enable pattern crossed with every legal rate and group within reach in serial mode, along with all 63 wrong address tags and all eight parallel pin codes. It also covers short, long and reserved words, mode round trips and the change pulse around each of them.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int EN_W     = 6;
  localparam int CH_N     = 4;
  localparam int ADDR_LO  = WORD_W - ADDR_W;
  localparam int EN_LO    = 4;
  localparam int RSV_BIT  = 3;
  localparam int RATE_BIT = 2;

  localparam logic [ADDR_W-1:0] ADDR_TAG = 6'b011100;

  localparam logic [1:0] GRP_48K  = 2'b00;
  localparam logic [1:0] GRP_RSVD = 2'b11;

  localparam logic [1:0] MULT_256 = 2'd0;
  localparam logic [1:0] MULT_384 = 2'd1;
  localparam logic [1:0] MULT_768 = 2'd2;

  typedef struct packed {
    logic [EN_W-1:0] en;
    logic            rate;
    logic [1:0]      grp;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{en: '1, rate: 1'b0, grp: GRP_48K};

  function automatic cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    cfg_t c;
    c.en   = w[EN_LO +: EN_W];
    c.rate = w[RATE_BIT];
    c.grp  = w[1:0];
    return c;
  endfunction

  function automatic logic [1:0] mult_for(int ch, logic dbl);
    case (ch)
      0:       return MULT_768;
      1:       return MULT_256;
      2:       return MULT_384;
      default: return dbl ? MULT_384 : MULT_768;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkcfg_rst_stretch.sv
module clkcfg_rst_stretch #(
  parameter int HOLD = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (por_i)           cnt_q <= '0;
    else if (cnt_q != HOLD_C) cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = (cnt_q != HOLD_C);

  AST_STRETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !por_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_POR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> busy_o); // R2
endmodule

// File: rtl/clkcfg_serial.sv
module clkcfg_serial
  import clkcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ml_i,
  input  logic              mc_i,
  input  logic              md_i,
  output logic              wr_valid_o,
  output logic [WORD_W-1:0] wr_word_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic              ml_q, mc_q;
  logic [WORD_W-1:0] shift_q;
  logic [CW-1:0]     cnt_q;
  logic              ml_rise, mc_rise;

  assign ml_rise = ml_i & ~ml_q & ~clr_i;
  assign mc_rise = mc_i & ~mc_q & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ml_q    <= 1'b0;
      mc_q    <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      ml_q <= ml_i;
      mc_q <= mc_i;
      if (clr_i) begin
        shift_q <= '0;
        cnt_q   <= '0;
      end else if (ml_rise) begin
        cnt_q <= '0;
      end else if (mc_rise) begin
        shift_q <= {shift_q[WORD_W-2:0], md_i};
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wr_word_o  = shift_q;
  assign wr_valid_o = ml_rise && (cnt_q == FULL)
                   && (shift_q[WORD_W-1:ADDR_LO] == ADDR_TAG)
                   && !shift_q[RSV_BIT]
                   && (shift_q[1:0] != GRP_RSVD);

  AST_LATCH_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ml_rise |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       mode_i,
  input  logic       ml_sr_i,
  input  logic       mc_fs1_i,
  input  logic       md_fs0_i,
  output logic [5:0] out_en_o,
  output logic       rate_dbl_o,
  output logic [1:0] group_o,
  output logic [7:0] mult_o,
  output logic       cfg_changed_o,
  output logic       rst_busy_o
);
  logic [3:0]        pins_s;
  logic              par_s, ml_s, mc_s, md_s;
  logic              busy;
  logic              wr_valid;
  logic [WORD_W-1:0] wr_word;
  cfg_t              cfg_q, eff, out_q;
  logic              chg_q;

  clkcfg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mode_i, ml_sr_i, mc_fs1_i, md_fs0_i}),
    .q_o   (pins_s)
  );
  assign {par_s, ml_s, mc_s, md_s} = pins_s;

  clkcfg_rst_stretch #(.HOLD(STRETCH_CYCLES)) u_stretch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .por_i (por_i),
    .busy_o(busy)
  );

  clkcfg_serial u_serial (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (busy | par_s),
    .ml_i      (ml_s),
    .mc_i      (mc_s),
    .md_i      (md_s),
    .wr_valid_o(wr_valid),
    .wr_word_o (wr_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_DEFAULT;
    else if (busy)     cfg_q <= CFG_DEFAULT;
    else if (wr_valid) cfg_q <= word_to_cfg(wr_word);
  end

  always_comb begin
    if (busy) begin
      eff = CFG_DEFAULT;
    end else if (par_s) begin
      eff.en   = '1;
      eff.rate = ml_s;
      eff.grp  = ({mc_s, md_s} == GRP_RSVD) ? GRP_48K : {mc_s, md_s};
    end else begin
      eff = cfg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= CFG_DEFAULT;
      chg_q <= 1'b0;
    end else begin
      out_q <= eff;
      chg_q <= !busy && (eff != out_q);
    end
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_mult
    assign mult_o[2*ch +: 2] = mult_for(ch, out_q.rate);
  end

  assign out_en_o      = out_q.en;
  assign rate_dbl_o    = out_q.rate;
  assign group_o       = out_q.grp;
  assign cfg_changed_o = chg_q;
  assign rst_busy_o    = busy;

  AST_RESET_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (out_q == CFG_DEFAULT)); // R1
  AST_PAR_ALL_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_s && !busy) |=> (out_en_o == '1)); // R7
  AST_REG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !wr_valid) |=> (cfg_q == $past(cfg_q))); // R4
  AST_CHG_MEANS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_changed_o |-> (out_q != $past(out_q))); // R10
  AST_SCK3_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_dbl_o |-> (mult_o[7:6] == MULT_384)); // R9
endmodule

// File: tb/clkcfg_ctrl_test.sv
module clkcfg_ctrl_test;
  localparam int STRETCH = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por = 1'b0, mode = 1'b0, ml = 1'b0, mc = 1'b0, md = 1'b0;
  logic [5:0] out_en;
  logic rate_dbl, chg, busy;
  logic [1:0] grp;
  logic [7:0] mult;

  int vectors = 0, fails = 0, pulses = 0;
  logic [8:0] cur = 9'h1F8;
  logic [8:0] ser = 9'h1F8;

  always #4 clk = ~clk;

  clkcfg_ctrl #(.STRETCH_CYCLES(STRETCH), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .mode_i(mode),
    .ml_sr_i(ml), .mc_fs1_i(mc), .md_fs0_i(md),
    .out_en_o(out_en), .rate_dbl_o(rate_dbl), .group_o(grp), .mult_o(mult),
    .cfg_changed_o(chg), .rst_busy_o(busy)
  );

  always @(posedge clk) if (rst_ni && chg) pulses <= pulses + 1;

  function automatic logic [1:0] mcode(int m);
    return (m == 256) ? 2'd0 : (m == 384) ? 2'd1 : 2'd2;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_cfg(string req, logic [8:0] e);
    int m3;
    m3 = e[2] ? 384 : 768;
    check(req, {out_en, rate_dbl, grp}, e);
    check({req, "/R9"}, mult, {mcode(m3), mcode(384), mcode(256), mcode(768)});
  endtask

  function automatic logic [15:0] mk(logic [5:0] en, logic r, logic [1:0] g);
    return {6'b011100, en, 1'b0, r, g};
  endfunction

  task automatic shift_out(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      md = w[i];
      repeat (3) @(negedge clk);
      mc = 1'b1;
      repeat (3) @(negedge clk);
      mc = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic serial(string req, logic [31:0] w, int n, bit accept);
    int p0;
    logic [8:0] nxt;
    p0 = pulses;
    shift_out(w, n);
    ml = 1'b1;
    repeat (4) @(negedge clk);
    ml = 1'b0;
    repeat (8) @(negedge clk);
    nxt = accept ? w[15:4] == 0 ? cur : {w[9:4], w[2], w[1:0]} : cur;
    check_cfg(req, nxt);
    check({req, "/R10"}, pulses - p0, (nxt != cur) ? 1 : 0);
    cur = nxt;
    ser = nxt;
  endtask

  task automatic parallel(logic sr, logic [1:0] fs);
    int p0;
    logic [8:0] nxt;
    p0 = pulses;
    mode = 1'b1; ml = sr; mc = fs[1]; md = fs[0];
    repeat (8) @(negedge clk);
    nxt = {6'h3F, sr, (fs == 2'b11) ? 2'b00 : fs};
    check_cfg("R7", nxt);
    check("R7/R10", pulses - p0, (nxt != cur) ? 1 : 0);
    cur = nxt;
  endtask

  task automatic to_serial();
    int p0;
    p0 = pulses;
    mode = 1'b0; ml = 1'b0; mc = 1'b0; md = 1'b0;
    repeat (8) @(negedge clk);
    check_cfg("R8", ser);
    check("R8/R10", pulses - p0, (ser != cur) ? 1 : 0);
    cur = ser;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int k, p0;
    repeat (3) @(negedge clk);
    check("R1", busy, 1);
    check_cfg("R1", 9'h1F8);
    check("R1", chg, 0);

    rst_ni = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == STRETCH / 2) check_cfg("R1", 9'h1F8);
    end while (busy && k < 1000);
    check("R2", k, STRETCH);

    for (int e = 0; e < 64; e++)
      for (int r = 0; r < 2; r++)
        for (int g = 0; g < 3; g++)
          serial("R3", {16'h0, mk(6'(e), 1'(r), 2'(g))}, 16, 1'b1);

    serial("R10", {16'h0, mk(cur[8:3], cur[2], cur[1:0])}, 16, 1'b1);

    for (int a = 0; a < 64; a++)
      if (6'(a) != 6'b011100)
        serial("R4", {16'h0, 6'(a), ~cur[8:3], 1'b0, ~cur[2], 2'b01}, 16, 1'b0);

    serial("R5", {16'h0, mk(~cur[8:3], ~cur[2], 2'b10)}, 15, 1'b0);
    serial("R5", {16'h1, mk(6'h15, 1'b1, 2'b10)}, 17, 1'b1);
    serial("R6", {16'h0, mk(~cur[8:3], ~cur[2], 2'b11)}, 16, 1'b0);
    serial("R6", {16'h0, 6'b011100, ~cur[8:3], 1'b1, ~cur[2], 2'b01}, 16, 1'b0);
    serial("R3", {16'h0, mk(6'h2A, 1'b1, 2'b01)}, 16, 1'b1);

    for (int c = 0; c < 8; c++) parallel(1'(c >> 2), 2'(c));
    to_serial();
    parallel(1'b0, 2'b00);
    to_serial();

    p0 = pulses;
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 2) begin
        check("R1", busy, 1);
        check_cfg("R1", 9'h1F8);
      end
    end while (busy && k < 1000);
    check("R2", k, STRETCH);
    repeat (4) @(negedge clk);
    check_cfg("R2", 9'h1F8);
    check("R1/R10", pulses - p0, 0);
    cur = 9'h1F8;
    ser = 9'h1F8;
    serial("R3", {16'h0, mk(6'h01, 1'b1, 2'b10)}, 16, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule